// File: doc/BRIEF.md
# Fixed-Point Lorenz Chaotic Generator

This block steps the three-variable Lorenz system with a forward Euler rule. It works in 55-bit signed fixed point: one sign bit, 12 integer bits and 42 fraction bits. The starting point and the three coefficients arrive on parallel inputs and are captured by a load strobe. While the run input is held high, the block produces one new (x, y, z) point on every clock.

Each product of two 55-bit numbers is formed at full 110-bit width. The product is brought back to the working format by keeping bits 96 down to 42. The time step of 2^-7 costs no multiplier: it is a 7-position arithmetic right shift of each increment.

Next to the full states, the block gives one random byte per state. Each byte is floor(state * 2^40) mod 256, which is bits 9 down to 2 of the state's raw word. These bytes are meant to feed share or keystream logic downstream.

A small control machine has three states:
- `ST_IDLE` holds after reset, when no state has been loaded.
- `ST_READY` means a state is loaded and paused.
- `ST_RUN` means the block is stepping.

Its transitions are:
- IDLE to READY on load.
- READY to RUN on run.
- RUN to READY when run drops.
- Any state to READY on load, since a load always wins.

Top module: `lorenz_gen`

## Requirements
- R1: After reset `valid_o` is 0, and every state and byte output is 0.
- R2: When `load_i` is high at a clock edge, the block captures the three start values and the three coefficients, whatever `run_i` is. From the next cycle the state outputs equal the start values and `valid_o` is 1.
- R3: On each stepping edge, x becomes x + ((sigma * (y - x))[96:42] >>> 7). The subtraction and the addition wrap modulo 2^55, and the product is taken modulo 2^110.
- R4: On each stepping edge, y becomes y + ((x * (rho - z))[96:42] >>> 7), with the same wrapping.
- R5: On each stepping edge, z becomes z + (((x * y)[96:42] - (beta * z)[96:42]) >>> 7), with the same wrapping.
- R6: All three next values are computed from the values present before the edge, so the three updates happen at the same time.
- R7: A stepping edge is one where `valid_o` is 1, `run_i` is 1 and `load_i` is 0. At any other edge after a load, the state outputs keep their values.
- R8: Before the first load, `run_i` has no effect: `valid_o` stays 0 and the state outputs stay 0.
- R9: A load in the middle of a run restarts the trajectory. With the same inputs it then gives exactly the same sequence as the first run.
- R10: Each byte output `xr_o`, `yr_o`, `zr_o` equals bits [9:2] of its state, that is floor(state * 2^40) mod 256.
- R11: Changes on the six start and coefficient inputs have no effect except at a load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture start point and coefficients |
| run_i | input | 1 | Advance one Euler step per clock |
| x0_i | input | 55 | Start value of x, signed Q12.42 |
| y0_i | input | 55 | Start value of y, signed Q12.42 |
| z0_i | input | 55 | Start value of z, signed Q12.42 |
| sigma_i | input | 55 | Coefficient sigma, signed Q12.42 |
| rho_i | input | 55 | Coefficient rho, signed Q12.42 |
| beta_i | input | 55 | Coefficient beta, signed Q12.42 |
| valid_o | output | 1 | A loaded state is present |
| x_o | output | 55 | Current x |
| y_o | output | 55 | Current y |
| z_o | output | 55 | Current z |
| xr_o | output | 8 | Random byte from x |
| yr_o | output | 8 | Random byte from y |
| zr_o | output | 8 | Random byte from z |

## Verification
The hardest case to reach from the ports is a negative product slice whose arithmetic shift rounds toward minus infinity. A single lost LSB there only shows up many steps later, once the chaos has amplified it. The stimulus reaches it in two ways. One start point sits a single LSB away from the origin. Other runs last hundreds of steps, so x and y cross zero many times. A bit-exact integer model in the bench is compared on every step. Pauses, and a reload in the middle of a run with the same inputs, test that the restart reproduces the trajectory.

// File: rtl/lorenz_pkg.sv
package lorenz_pkg;

    // Control states of the generator
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_RUN   = 2'd2
    } lz_state_e;

endpackage

// File: rtl/lorenz_ctrl.sv
module lorenz_ctrl
    import lorenz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic capture_o,
    output logic advance_o,
    output logic valid_o
);

    lz_state_e st_q;
    lz_state_e st_nxt;

    // Next-state logic: a load always wins over run
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (load_i) st_nxt = ST_READY;
            end
            ST_READY: begin
                if (load_i)     st_nxt = ST_READY;
                else if (run_i) st_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (load_i || !run_i) st_nxt = ST_READY;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // Outputs
    always_comb begin
        capture_o = load_i;
        advance_o = 1'b0;
        valid_o   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                advance_o = 1'b0;
                valid_o   = 1'b0;
            end
            ST_READY, ST_RUN: begin
                advance_o = run_i && !load_i;
                valid_o   = 1'b1;
            end
            default: begin
                advance_o = 1'b0;
                valid_o   = 1'b0;
            end
        endcase
    end

    // R2
    load_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q == ST_READY));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !load_i) |=> (st_q == ST_IDLE));

    // R2
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);

endmodule

// File: rtl/lorenz_fxmul.sv
module lorenz_fxmul #(
    parameter int W = 55,
    parameter int F = 42
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] p_o
);

    localparam int PW = 2 * W;

    logic [PW-1:0] full;

    // Low PW bits of the product are the same for signed or unsigned operands
    assign full = {{W{a_i[W-1]}}, a_i} * {{W{b_i[W-1]}}, b_i};
    assign p_o  = W'(full >> F);

endmodule

// File: rtl/lorenz_step.sv
module lorenz_step #(
    parameter int W = 55,
    parameter int F = 42,
    parameter int H = 7
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    input  logic [W-1:0] sig_i,
    input  logic [W-1:0] rho_i,
    input  logic [W-1:0] beta_i,
    output logic [W-1:0] x_o,
    output logic [W-1:0] y_o,
    output logic [W-1:0] z_o
);

    localparam int NMUL = 4;

    logic [W-1:0] op_a [NMUL];
    logic [W-1:0] op_b [NMUL];
    logic [W-1:0] prod [NMUL];
    logic [W-1:0] zdiff;
    logic [W-1:0] dx, dy, dz;

    // Operand routing: sigma*(y-x), x*(rho-z), x*y, beta*z
    always_comb begin
        op_a[0] = sig_i;
        op_b[0] = y_i - x_i;
        op_a[1] = x_i;
        op_b[1] = rho_i - z_i;
        op_a[2] = x_i;
        op_b[2] = y_i;
        op_a[3] = beta_i;
        op_b[3] = z_i;
    end

    for (genvar i = 0; i < NMUL; i++) begin : g_mul
        lorenz_fxmul #(.W(W), .F(F)) u_mul (
            .a_i (op_a[i]),
            .b_i (op_b[i]),
            .p_o (prod[i])
        );
    end

    // Time step as arithmetic shift
    always_comb begin
        zdiff = prod[2] - prod[3];
        dx    = W'($signed(prod[0]) >>> H);
        dy    = W'($signed(prod[1]) >>> H);
        dz    = W'($signed(zdiff) >>> H);
        x_o   = x_i + dx;
        y_o   = y_i + dy;
        z_o   = z_i + dz;
    end

endmodule

// File: rtl/lorenz_gen.sv
module lorenz_gen #(
    parameter int W      = 55,
    parameter int F      = 42,
    parameter int H      = 7,
    parameter int SCALE  = 40,
    parameter int RBITS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [W-1:0]     x0_i,
    input  logic [W-1:0]     y0_i,
    input  logic [W-1:0]     z0_i,
    input  logic [W-1:0]     sigma_i,
    input  logic [W-1:0]     rho_i,
    input  logic [W-1:0]     beta_i,
    output logic             valid_o,
    output logic [W-1:0]     x_o,
    output logic [W-1:0]     y_o,
    output logic [W-1:0]     z_o,
    output logic [RBITS-1:0] xr_o,
    output logic [RBITS-1:0] yr_o,
    output logic [RBITS-1:0] zr_o
);

    localparam int RLSB = F - SCALE;

    logic         capture, advance;
    logic [W-1:0] x_q, y_q, z_q;
    logic [W-1:0] sig_q, rho_q, beta_q;
    logic [W-1:0] x_n, y_n, z_n;

    lorenz_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .run_i     (run_i),
        .capture_o (capture),
        .advance_o (advance),
        .valid_o   (valid_o)
    );

    lorenz_step #(.W(W), .F(F), .H(H)) u_step (
        .x_i    (x_q),
        .y_i    (y_q),
        .z_i    (z_q),
        .sig_i  (sig_q),
        .rho_i  (rho_q),
        .beta_i (beta_q),
        .x_o    (x_n),
        .y_o    (y_n),
        .z_o    (z_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
            sig_q  <= '0;
            rho_q  <= '0;
            beta_q <= '0;
        end else if (capture) begin
            x_q    <= x0_i;
            y_q    <= y0_i;
            z_q    <= z0_i;
            sig_q  <= sigma_i;
            rho_q  <= rho_i;
            beta_q <= beta_i;
        end else if (advance) begin
            x_q <= x_n;
            y_q <= y_n;
            z_q <= z_n;
        end
    end

    assign x_o  = x_q;
    assign y_o  = y_q;
    assign z_o  = z_q;
    assign xr_o = RBITS'(x_q >> RLSB);
    assign yr_o = RBITS'(y_q >> RLSB);
    assign zr_o = RBITS'(z_q >> RLSB);

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (x_o == $past(x0_i) && y_o == $past(y0_i) && z_o == $past(z0_i)));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !run_i) |=> ($stable(x_o) && $stable(y_o) && $stable(z_o)));

    // R11
    coef_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(sig_q) && $stable(rho_q) && $stable(beta_q)));

endmodule

// File: tb/lorenz_gen_tb_top.sv
module lorenz_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic        run_i = 1'b0;
    logic [54:0] x0_i = '0, y0_i = '0, z0_i = '0;
    logic [54:0] sigma_i = '0, rho_i = '0, beta_i = '0;
    logic        valid_o;
    logic [54:0] x_o, y_o, z_o;
    logic [7:0]  xr_o, yr_o, zr_o;

    int checks = 0;
    int failures = 0;

    logic [54:0] mx, my, mz, ms, mr, mb;

    always #10 clk = ~clk;

    lorenz_gen dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .run_i(run_i),
        .x0_i(x0_i), .y0_i(y0_i), .z0_i(z0_i),
        .sigma_i(sigma_i), .rho_i(rho_i), .beta_i(beta_i),
        .valid_o(valid_o), .x_o(x_o), .y_o(y_o), .z_o(z_o),
        .xr_o(xr_o), .yr_o(yr_o), .zr_o(zr_o)
    );

    function automatic logic [54:0] fx(input int v);
        logic [54:0] t;
        t = 55'(signed'(v));
        return t << 42;
    endfunction

    function automatic logic [54:0] fmul(input logic [54:0] a, input logic [54:0] b);
        logic [109:0] f;
        f = {{55{a[54]}}, a} * {{55{b[54]}}, b};
        return f[96:42];
    endfunction

    function automatic logic [54:0] sh7(input logic [54:0] v);
        logic signed [54:0] s;
        s = v;
        return s >>> 7;
    endfunction

    task automatic model_step();
        logic [54:0] nx, ny, nz;
        nx = mx + sh7(fmul(ms, my - mx));
        ny = my + sh7(fmul(mx, mr - mz));
        nz = mz + sh7(fmul(mx, my) - fmul(mb, mz));
        mx = nx; my = ny; mz = nz;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmp_all(input string tx, input string ty, input string tz);
        chk(tx, 64'(x_o), 64'(mx));
        chk(ty, 64'(y_o), 64'(my));
        chk(tz, 64'(z_o), 64'(mz));
        chk("R10 x byte", 64'(xr_o), 64'(mx[9:2]));
        chk("R10 y byte", 64'(yr_o), 64'(my[9:2]));
        chk("R10 z byte", 64'(zr_o), 64'(mz[9:2]));
    endtask

    task automatic do_load(input logic [54:0] a, b, c, s, r, bt);
        @(negedge clk);
        load_i = 1'b1;
        x0_i = a; y0_i = b; z0_i = c;
        sigma_i = s; rho_i = r; beta_i = bt;
        @(negedge clk);
        load_i = 1'b0;
        mx = a; my = b; mz = c; ms = s; mr = r; mb = bt;
        chk("R2 valid", 64'(valid_o), 64'd1);
        cmp_all("R2 x", "R2 y", "R2 z");
    endtask

    task automatic run_steps(input int n, input bit scramble);
        run_i = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (scramble) begin
                x0_i = x0_i ^ 55'h5A5A5A5A5A5A5A;
                sigma_i = sigma_i + 55'h123456789;
                rho_i = ~rho_i;
                beta_i = beta_i ^ 55'h1F;
            end
            @(negedge clk);
            model_step();
            if (scramble) cmp_all("R11 x", "R11 y", "R11 z");
            else          cmp_all("R3 x", "R4 y", "R5 z R6");
        end
    endtask

    task automatic hold_cycles(input int n);
        run_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmp_all("R7 x", "R7 y", "R7 z");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [54:0] b83;
        b83 = (fx(8)) / 55'd3;
        repeat (3) @(negedge clk);
        chk("R1 valid", 64'(valid_o), 64'd0);
        chk("R1 x", 64'(x_o), 64'd0);
        chk("R1 z", 64'(z_o), 64'd0);
        chk("R1 byte", 64'(yr_o), 64'd0);
        rst_n = 1'b1;

        // R8: run before any load
        run_i = 1'b1;
        x0_i = fx(3);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R8 valid", 64'(valid_o), 64'd0);
            chk("R8 x", 64'(x_o), 64'd0);
        end

        // Set 1: standard coefficients, loaded while run is high
        do_load(fx(1), fx(1), fx(1), fx(10), fx(28), b83);
        run_steps(400, 1'b0);
        hold_cycles(5);
        run_steps(100, 1'b0);

        // R9: reload same values mid-run and repeat the trajectory
        do_load(fx(1), fx(1), fx(1), fx(10), fx(28), b83);
        run_steps(500, 1'b0);

        // Set 2: negative start, with coefficient inputs scrambled (R11)
        do_load(fx(-8), fx(7), fx(27), fx(10), fx(28), b83);
        run_steps(400, 1'b1);
        hold_cycles(3);

        // Set 3: one-LSB start near the origin
        do_load(55'd1, 55'd0, 55'd0, fx(10), fx(28), b83);
        run_steps(400, 1'b0);

        // Set 4: other coefficients and a negative y
        do_load(fx(2), fx(-3), fx(40), fx(16), fx(45), fx(4));
        run_steps(500, 1'b0);

        run_i = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule